// File: doc/BRIEF.md
# Dual Parallel-Port I/O Controller

This block gives a host 48 general-purpose digital lines through two independent programmable parallel interfaces. Both run only in basic latched mode. Each interface has three 8-bit ports, called A, B and C, and a write-only configuration byte that sets each port's direction. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. The host reaches everything through a small 8-bit register bus that spans eight byte offsets. Address bit 2 picks the interface. Address bits 1..0 pick port A (0), port B (1), port C (2) or the configuration byte (3).

On the pin side, each line has three signals: an output value, an output enable and an input. The output value always carries the line's latch. The output enable is high only while the line is configured as an output. Pin levels pass through a synchronizer before the bus can read them. A port read is assembled bit by bit: output lines return the latch and input lines return the synchronized pin.

A configuration write with bit 7 clear does not change the directions. It sets or clears one bit of port C, so software can change a single port C line without rewriting the whole port.

Top module: `dual_ppi_io`

## Requirements
- R1: After reset all 48 output enables are low, all 48 output values are 0, and every line is an input.
- R2: Address bit 2 selects the interface. Offsets 0/1/2 are ports A/B/C of interface 0 and offsets 4/5/6 are ports A/B/C of interface 1. Pin index = interface*24 + port*8 + bit, with A=0, B=1, C=2.
- R3: A configuration write with bit 7 set sets the directions. Bit 4 is port A and bit 1 is port B, with 1 meaning input and 0 meaning output. Directions change only on such a write.
- R4: In the same write, bit 3 sets the direction of port C bits 7..4 and bit 0 sets port C bits 3..0. Each nibble switches as a unit.
- R5: Every direction write clears all three latches of its own interface to 0. Writing 0x80 makes all 24 lines of that interface outputs.
- R6: Bits 6, 5 and 2 of a direction write are ignored.
- R7: A write to a port offset loads that port's latch in the same clock edge. The latch drives the output value of all eight bits, and the output enable is high only on output bits.
- R8: A read returns, for each input bit, the pin level delayed by a two-stage synchronizer. A pin change made before edge k is readable just after edge k+1.
- R9: A read returns the latch value for each output bit.
- R10: A configuration write with bit 7 clear sets port C bit [3:1] to the value of bit 0. It changes no other latch bit and no direction.
- R11: A read of a configuration offset (3 or 7) returns 0xFF. With the read strobe low, read data is 0.
- R12: The two interfaces are independent. Writes to one change neither the latches nor the directions of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset within the window |
| busWr | input | 1 | Write strobe, sampled at the clock edge |
| busRd | input | 1 | Read strobe, enables read data |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| pinIn | input | 48 | Pin levels, asynchronous |
| pinOut | output | 48 | Output value per line |
| pinOe | output | 48 | Output enable per line |

## Verification
The bench targets the split port C direction. It configures each nibble alone as an input and checks that a read merges pin bits and latch bits at the nibble boundary. A design that treated port C as one unit, or swapped the two control bits, would return a wrong half. It checks that a direction write clears the latches and that a single-bit command leaves the latches and directions alone, so a decoder that confused the two command types shows up as lost data. It sets the ignored mode bits to show they change nothing, and it writes interface 1 to show interface 0 keeps its state. It counts the exact synchronizer latency by sampling read data after each clock edge following a pin change.

// File: rtl/dppi_pkg.sv
package dppi_pkg;
  localparam int UNITS      = 2;
  localparam int BYTE_W     = 8;
  localparam int PORTS      = 3;
  localparam int UNIT_W     = PORTS * BYTE_W;
  localparam int LINES      = UNITS * UNIT_W;
  localparam int UNIT_SEL_W = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam int ADDR_W     = UNIT_SEL_W + 2;

  typedef struct packed {
    logic [UNITS-1:0][PORTS-1:0] portWr;
    logic [UNITS-1:0]            modeWr;
    logic [UNITS-1:0]            bitWr;
    logic [BYTE_W-1:0]           data;
  } strobe_t;
endpackage

// File: rtl/dppi_ctrl.sv
module dppi_ctrl
  import dppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [BYTE_W-1:0] busWdata,
  output strobe_t           strb
);
  logic [UNIT_SEL_W-1:0] unitIdx;
  logic [1:0]            regIdx;

  assign unitIdx = busAddr[ADDR_W-1:2];
  assign regIdx  = busAddr[1:0];

  always_comb begin
    strb      = '0;
    strb.data = busWdata;
    if (busWr) begin
      if (regIdx == 2'd3) begin
        if (busWdata[BYTE_W-1]) strb.modeWr[unitIdx] = 1'b1;
        else                    strb.bitWr[unitIdx]  = 1'b1;
      end else begin
        strb.portWr[unitIdx][regIdx] = 1'b1;
      end
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.portWr, strb.modeWr, strb.bitWr}));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> ({strb.portWr, strb.modeWr, strb.bitWr} == '0));
endmodule

// File: rtl/dppi_datapath.sv
module dppi_datapath
  import dppi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic [LINES-1:0]  pinIn,
  output logic [BYTE_W-1:0] busRdata,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe
);
  localparam int NIB = BYTE_W / 2;

  logic [SYNC_STAGES-1:0][LINES-1:0] syncPipe;
  logic [UNITS-1:0][PORTS-1:0][BYTE_W-1:0] portView;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else begin
      syncPipe[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [PORTS-1:0][BYTE_W-1:0] latch;
    logic dirA, dirB, dirCu, dirCl;
    logic [UNIT_W-1:0] inMask;
    logic [BYTE_W-1:0] portCOut;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        latch <= '0;
        dirA  <= 1'b1;
        dirB  <= 1'b1;
        dirCu <= 1'b1;
        dirCl <= 1'b1;
      end else if (strb.modeWr[u]) begin
        latch <= '0;
        dirA  <= strb.data[4];
        dirB  <= strb.data[1];
        dirCu <= strb.data[3];
        dirCl <= strb.data[0];
      end else if (strb.bitWr[u]) begin
        latch[2][strb.data[3:1]] <= strb.data[0];
      end else begin
        for (int p = 0; p < PORTS; p++)
          if (strb.portWr[u][p]) latch[p] <= strb.data;
      end
    end

    assign inMask = {{NIB{dirCu}}, {NIB{dirCl}}, {BYTE_W{dirB}}, {BYTE_W{dirA}}};
    assign pinOut[u*UNIT_W +: UNIT_W] = latch;
    assign pinOe[u*UNIT_W +: UNIT_W]  = ~inMask;
    assign portView[u] = (latch & ~inMask)
                       | (syncPipe[SYNC_STAGES-1][u*UNIT_W +: UNIT_W] & inMask);
    assign portCOut = pinOut[u*UNIT_W + 2*BYTE_W +: BYTE_W];

    // R5
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.modeWr[u] |=> (pinOut[u*UNIT_W +: UNIT_W] == '0));

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.modeWr[u] |=> $stable(pinOe[u*UNIT_W +: UNIT_W]));

    // R7
    port_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.portWr[u][0] |=> (pinOut[u*UNIT_W +: BYTE_W] == $past(strb.data)));

    // R10
    bit_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.bitWr[u] |=> (portCOut[$past(strb.data[3:1])] == $past(strb.data[0])));
  end

  logic [UNIT_SEL_W-1:0] rdUnit;
  logic [1:0]            rdReg;
  assign rdUnit = busAddr[ADDR_W-1:2];
  assign rdReg  = busAddr[1:0];

  always_comb begin
    if (!busRd)              busRdata = '0;
    else if (rdReg == 2'd3)  busRdata = '1;
    else                     busRdata = portView[rdUnit][rdReg];
  end
endmodule

// File: rtl/dual_ppi_io.sv
module dual_ppi_io
  import dppi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe
);
  strobe_t strb;

  dppi_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .strb     (strb)
  );

  dppi_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );
endmodule

// File: tb/tb_dual_ppi_io.sv
module tb_dual_ppi_io;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 42;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [47:0] pinIn = 48'h123456_89ABCD;
  logic [47:0] pinOut;
  logic [47:0] pinOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_ppi_io dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // entry = {isRead, addr, data (write value or expected read), requirement number}
  // Pins: unit0 A=CD B=AB C=89, unit1 A=56 B=34 C=12
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 8'hCD, 8'd8 },  // R8 input after reset
    {1'b1, 3'd4, 8'h56, 8'd8 },  // R8
    {1'b1, 3'd3, 8'hFF, 8'd11},  // R11
    {1'b0, 3'd3, 8'h80, 8'd5 },  // R5 all outputs
    {1'b0, 3'd0, 8'h11, 8'd7 },  // R7
    {1'b1, 3'd0, 8'h11, 8'd9 },  // R9
    {1'b1, 3'd1, 8'h00, 8'd5 },
    {1'b0, 3'd2, 8'h5A, 8'd7 },
    {1'b1, 3'd2, 8'h5A, 8'd9 },
    {1'b1, 3'd6, 8'h12, 8'd12},  // R12 unit1 still input
    {1'b0, 3'd3, 8'h89, 8'd4 },  // R4 C both nibbles input
    {1'b1, 3'd2, 8'h89, 8'd4 },
    {1'b1, 3'd0, 8'h00, 8'd5 },  // latch cleared
    {1'b0, 3'd3, 8'h82, 8'd3 },  // R3 B input only
    {1'b1, 3'd1, 8'hAB, 8'd3 },
    {1'b1, 3'd2, 8'h00, 8'd3 },
    {1'b0, 3'd3, 8'h88, 8'd4 },  // upper nibble input
    {1'b0, 3'd2, 8'hFF, 8'd4 },
    {1'b1, 3'd2, 8'h8F, 8'd4 },
    {1'b0, 3'd3, 8'h81, 8'd4 },  // lower nibble input
    {1'b0, 3'd2, 8'hFF, 8'd4 },
    {1'b1, 3'd2, 8'hF9, 8'd4 },
    {1'b0, 3'd3, 8'hE4, 8'd6 },  // R6 mode bits ignored
    {1'b0, 3'd0, 8'h3C, 8'd6 },
    {1'b1, 3'd0, 8'h3C, 8'd6 },
    {1'b1, 3'd2, 8'h00, 8'd6 },
    {1'b0, 3'd3, 8'h0F, 8'd10},  // R10 set C7
    {1'b1, 3'd2, 8'h80, 8'd10},
    {1'b0, 3'd3, 8'h03, 8'd10},  // set C1
    {1'b1, 3'd2, 8'h82, 8'd10},
    {1'b0, 3'd3, 8'h02, 8'd10},  // clear C1
    {1'b1, 3'd2, 8'h80, 8'd10},
    {1'b1, 3'd0, 8'h3C, 8'd10},
    {1'b0, 3'd7, 8'h80, 8'd12},
    {1'b0, 3'd4, 8'hA5, 8'd2 },  // R2
    {1'b0, 3'd5, 8'h77, 8'd2 },
    {1'b0, 3'd6, 8'h0F, 8'd2 },
    {1'b1, 3'd4, 8'hA5, 8'd2 },
    {1'b1, 3'd5, 8'h77, 8'd2 },
    {1'b1, 3'd6, 8'h0F, 8'd2 },
    {1'b1, 3'd0, 8'h3C, 8'd12},
    {1'b1, 3'd7, 8'hFF, 8'd11}
  };

  task automatic checkVal(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVal("R1 oe", pinOe, 48'h0);
    checkVal("R1 out", pinOut, 48'h0);
    checkVal("R11 idle rdata", {40'h0, busRdata}, 48'h0);
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) begin
        busRead(VEC[i][18:16], rd);
        checkVal($sformatf("R%0d vec%0d", VEC[i][7:0], i), {40'h0, rd}, {40'h0, VEC[i][15:8]});
      end else begin
        busWrite(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R7 pin-level outputs
    checkVal("R7 out", pinOut, 48'h0F77A5_80003C);
    checkVal("R7 oe", pinOe, 48'hFFFFFF_FFFFFF);

    // R3 unit1 back to inputs; R5 its latches clear; R12 unit0 kept
    busWrite(3'd7, 8'h9B);
    checkVal("R3 oe", pinOe, 48'h000000_FFFFFF);
    checkVal("R5 out", pinOut, 48'h000000_80003C);

    // R8 synchronizer latency
    @(negedge clk);
    pinIn[31:24] = 8'h3E;
    busAddr = 3'd4; busRd = 1'b1;
    @(posedge clk); #1;
    checkVal("R8 one edge", {40'h0, busRdata}, 48'h56);
    @(posedge clk); #1;
    checkVal("R8 two edges", {40'h0, busRdata}, 48'h3E);
    busRd = 1'b0;
    #1 checkVal("R11 rd low", {40'h0, busRdata}, 48'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule